// File: doc/BRIEF.md
# Clock-Gating Control Register Bank

This block is the system-control register file of an I/O clock domain. It holds a flat array of 32-bit words reached over a simple word-addressed bus: an address, a write enable, write data, and combinational read data. Most words are plain storage. A few words load fixed values at reset: the identification word, two clock-select words and a PLL parameter word.

Two of the words are clock-stop vectors, and each one has a second address one word above it. A write to the main address can only set bits. A write to the upper address clears, in the main word, every bit written as 1, and nothing is stored at the upper address.

The two stop vectors and the peripheral-clock divider field (bits [20:18] of the first clock-select word) are driven straight out to the clock tree. The APB clock of the domain is the HPLL output divided by (field + 1) and then by 2.

The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `clkgate_regs`

## Requirements
- R1: After reset, the following words hold these values: word 0 = 0x06000003, word 144 (stop vector A) = 0xFFFF8400, word 152 (stop vector B) = 0x00005F30, word 160 (clock select 1) = 0x86900000, word 161 (clock select 2) = 0x00400000, word 192 (HPLL parameter) = 0x10000027.
- R2: Every other word reads zero after reset.
- R3: A write to word 144 or word 152 ORs the write data into that stop vector, so no bit that was already 1 is cleared.
- R4: A write to word 145 or word 153 clears each bit of the stop vector one word below that is written as 1, and leaves the bits written as 0 unchanged.
- R5: A write to a clear address stores nothing there, and both clear addresses always read zero.
- R6: A write to any other word below index 904 stores all 32 bits. From the next clock edge on, a read of that word returns them.
- R7: A read at word index 904 or above returns zero.
- R8: A write at word index 904 or above changes no word and no output.
- R9: `pclk_div_sel` always equals bits [20:18] of word 160. It is 4 after reset.
- R10: `clk_stop_a` and `clk_stop_b` always equal words 144 and 152.
- R11: Stored state changes only on a rising clock edge with `bus_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word index |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| clk_stop_a | output | 32 | Stop vector A (word 144) |
| clk_stop_b | output | 32 | Stop vector B (word 152) |
| pclk_div_sel | output | 3 | Peripheral-clock divider field |

## Verification
Some properties are checked on every cycle. For the stop vectors: a set write never drops a 1, a clear write removes exactly the bits written as 1, and an idle cycle holds both vectors. The checks also cover exclusive address decoding, zero read data out of range, outputs that do not move on an out-of-range write, and a plain write landing in the addressed word. Only the bench scenarios show the actual reset values, the zero read-back of the clear addresses, and a sequence of set and clear writes arriving at a known value. They also show that a second reset restores every word.

// File: rtl/clkgate_regs_pkg.sv
package clkgate_regs_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SPAN_BYTES = 32'hE20;
  localparam int unsigned NUM_WORDS  = SPAN_BYTES / 4;
  localparam int unsigned ADDR_W     = $clog2(NUM_WORDS);

  localparam int unsigned NUM_STOP   = 2;
  localparam int unsigned STOP_A_IDX = 32'h240 / 4;
  localparam int unsigned STOP_B_IDX = 32'h260 / 4;
  localparam int unsigned SEL1_IDX   = 32'h280 / 4;
  localparam int unsigned SEL2_IDX   = 32'h284 / 4;
  localparam int unsigned HPLL_IDX   = 32'h300 / 4;
  localparam int unsigned ID_IDX     = 0;

  localparam int unsigned PDIV_LSB   = 18;
  localparam int unsigned PDIV_W     = 3;

  localparam logic [DATA_W-1:0] STOP_A_RST = 32'hFFFF_8400;
  localparam logic [DATA_W-1:0] STOP_B_RST = 32'h0000_5F30;
  localparam logic [DATA_W-1:0] SEL1_RST   = 32'h8690_0000;
  localparam logic [DATA_W-1:0] SEL2_RST   = 32'h0040_0000;
  localparam logic [DATA_W-1:0] HPLL_RST   = 32'h1000_0027;
  localparam logic [DATA_W-1:0] ID_RST     = 32'h0600_0003;

  // Reset image of the plain storage array; stop words live elsewhere.
  function automatic logic [DATA_W-1:0] store_reset(input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == ID_IDX)   v = ID_RST;
    if (idx == SEL1_IDX) v = SEL1_RST;
    if (idx == SEL2_IDX) v = SEL2_RST;
    if (idx == HPLL_IDX) v = HPLL_RST;
    return v;
  endfunction
endpackage

// File: rtl/clkgate_regs_rstsync.sv
module clkgate_regs_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkgate_regs_decode.sv
module clkgate_regs_decode
  import clkgate_regs_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NWORDS = NUM_WORDS,
  parameter int unsigned NSTOP  = NUM_STOP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  output logic             in_range,
  output logic [NSTOP-1:0] hit_ctl,
  output logic [NSTOP-1:0] hit_clr,
  output logic             hit_plain
);
  localparam logic [AW:0] LIMIT = NWORDS[AW:0];
  localparam int unsigned STOP_IDX [NSTOP] = '{STOP_A_IDX, STOP_B_IDX};

  assign in_range = ({1'b0, addr} < LIMIT);

  for (genvar g = 0; g < NSTOP; g++) begin : g_stop
    localparam logic [AW-1:0] CTL_A = STOP_IDX[g][AW-1:0];
    localparam logic [AW-1:0] CLR_A = CTL_A + 1'b1;
    assign hit_ctl[g] = in_range && (addr == CTL_A);
    assign hit_clr[g] = in_range && (addr == CLR_A);
  end

  assign hit_plain = in_range && (hit_ctl == '0) && (hit_clr == '0);

  // R5: one access class at most per address
  a_r5_exclusive_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ctl, hit_clr, hit_plain}));

  // R7, R8: nothing decodes beyond the last word
  a_r8_oor_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (hit_ctl == '0) && (hit_clr == '0) && !hit_plain);
endmodule

// File: rtl/clkgate_regs_stopword.sv
module clkgate_regs_stopword #(
  parameter int unsigned    DW        = 32,
  parameter logic [DW-1:0]  RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          q_en;

  assign q_en = set_we | clr_we;

  always_comb begin
    q_nxt = q;
    if (set_we)      q_nxt = q | wdata;
    else if (clr_we) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (q_en) q <= q_nxt;
  end

  // R3: a set write never drops a bit that was 1
  a_r3_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(q)) == $past(q)) && ((q & $past(wdata)) == $past(wdata)));

  // R4: a clear write removes exactly the bits written as 1
  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0)
                          && ((q | $past(wdata)) == ($past(q) | $past(wdata))));

  // R11: no write, no change
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/clkgate_regs_store.sv
module clkgate_regs_store
  import clkgate_regs_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NWORDS = NUM_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] sel1_q
);
  localparam logic [AW:0] LIMIT = NWORDS[AW:0];

  logic [DW-1:0] mem [NWORDS];
  logic [AW-1:0] ridx;
  logic [AW-1:0] widx;

  always_comb begin
    ridx = ({1'b0, raddr} < LIMIT) ? raddr : '0;
    widx = ({1'b0, waddr} < LIMIT) ? waddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= store_reset(i);
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata  = mem[ridx];
  assign sel1_q = mem[SEL1_IDX];

  // R6: a plain write lands in the addressed word
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/clkgate_regs.sv
module clkgate_regs
  import clkgate_regs_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NWORDS = NUM_WORDS,
  parameter int unsigned PW     = PDIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] clk_stop_a,
  output logic [DW-1:0] clk_stop_b,
  output logic [PW-1:0] pclk_div_sel
);
  localparam int unsigned NSTOP = NUM_STOP;
  localparam logic [AW:0] LIMIT = NWORDS[AW:0];
  localparam logic [DW-1:0] STOP_RST [NSTOP] = '{STOP_A_RST, STOP_B_RST};

  logic             rst_n_i;
  logic             in_range;
  logic [NSTOP-1:0] hit_ctl;
  logic [NSTOP-1:0] hit_clr;
  logic             hit_plain;
  logic [DW-1:0]    store_rdata;
  logic [DW-1:0]    sel1_q;
  logic [DW-1:0]    stop_q [NSTOP];
  logic [DW-1:0]    rdata_mux;

  clkgate_regs_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  clkgate_regs_decode #(.AW(AW), .NWORDS(NWORDS), .NSTOP(NSTOP)) u_dec (
    .clk(clk), .rst_n(rst_n_i), .addr(bus_addr), .in_range(in_range),
    .hit_ctl(hit_ctl), .hit_clr(hit_clr), .hit_plain(hit_plain)
  );

  clkgate_regs_store #(.DW(DW), .AW(AW), .NWORDS(NWORDS)) u_store (
    .clk(clk), .rst_n(rst_n_i), .we(bus_we && hit_plain),
    .waddr(bus_addr), .wdata(bus_wdata), .raddr(bus_addr),
    .rdata(store_rdata), .sel1_q(sel1_q)
  );

  for (genvar g = 0; g < NSTOP; g++) begin : g_stop
    clkgate_regs_stopword #(.DW(DW), .RESET_VAL(STOP_RST[g])) u_word (
      .clk(clk), .rst_n(rst_n_i),
      .set_we(bus_we && hit_ctl[g]),
      .clr_we(bus_we && hit_clr[g]),
      .wdata(bus_wdata), .q(stop_q[g])
    );
  end

  // Clear addresses are never written in the store, so they read their reset zero.
  always_comb begin
    rdata_mux = store_rdata;
    for (int i = 0; i < NSTOP; i++) begin
      if (hit_ctl[i]) rdata_mux = stop_q[i];
    end
    if (!in_range) rdata_mux = '0;
  end

  assign bus_rdata    = rdata_mux;
  assign clk_stop_a   = stop_q[0];
  assign clk_stop_b   = stop_q[1];
  assign pclk_div_sel = sel1_q[PDIV_LSB +: PW];

  // R7: out-of-range reads return zero
  a_r7_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    ({1'b0, bus_addr} >= LIMIT) |-> (bus_rdata == '0));

  // R8: out-of-range writes leave the outputs alone
  a_r8_oor_write_dropped: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_we && ({1'b0, bus_addr} >= LIMIT)) |=>
      $stable(clk_stop_a) && $stable(clk_stop_b) && $stable(pclk_div_sel));

  // R9: a write to clock select 1 updates the divider field
  a_r9_div_follows: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_we && (bus_addr == AW'(SEL1_IDX))) |=>
      (pclk_div_sel == $past(bus_wdata[PDIV_LSB +: PW])));
endmodule

// File: tb/clkgate_regs_test.sv
module clkgate_regs_test;
  typedef struct packed {
    logic        we;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [9:0]  chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd0,    32'h0,         10'd0,   32'h0600_0003, 4'd1},  // R1 id
    '{1'b0, 10'd0,    32'h0,         10'd144, 32'hFFFF_8400, 4'd1},  // R1 stop A
    '{1'b0, 10'd0,    32'h0,         10'd152, 32'h0000_5F30, 4'd1},  // R1 stop B
    '{1'b0, 10'd0,    32'h0,         10'd160, 32'h8690_0000, 4'd1},  // R1 sel1
    '{1'b0, 10'd0,    32'h0,         10'd161, 32'h0040_0000, 4'd1},  // R1 sel2
    '{1'b0, 10'd0,    32'h0,         10'd192, 32'h1000_0027, 4'd1},  // R1 hpll
    '{1'b0, 10'd0,    32'h0,         10'd5,   32'h0,         4'd2},  // R2
    '{1'b0, 10'd0,    32'h0,         10'd903, 32'h0,         4'd2},  // R2 last word
    '{1'b1, 10'd144,  32'h0000_00F3, 10'd144, 32'hFFFF_84F3, 4'd3},  // R3 OR in
    '{1'b1, 10'd145,  32'hFFFF_0001, 10'd144, 32'h0000_84F2, 4'd4},  // R4 clear ones
    '{1'b0, 10'd0,    32'h0,         10'd145, 32'h0,         4'd5},  // R5 alias reads 0
    '{1'b1, 10'd152,  32'h0,         10'd152, 32'h0000_5F30, 4'd3},  // R3 zero write
    '{1'b1, 10'd153,  32'h0000_0F00, 10'd152, 32'h0000_5030, 4'd4},  // R4
    '{1'b1, 10'd152,  32'h8000_0001, 10'd152, 32'h8000_5031, 4'd3},  // R3
    '{1'b1, 10'd153,  32'h8000_0000, 10'd153, 32'h0,         4'd5},  // R5 not stored
    '{1'b1, 10'd7,    32'hDEAD_BEEF, 10'd7,   32'hDEAD_BEEF, 4'd6},  // R6
    '{1'b1, 10'd903,  32'hA5A5_5A5A, 10'd903, 32'hA5A5_5A5A, 4'd6},  // R6 last word
    '{1'b1, 10'd1000, 32'h1234_5678, 10'd1000,32'h0,         4'd7},  // R7
    '{1'b1, 10'd1023, 32'hFFFF_FFFF, 10'd903, 32'hA5A5_5A5A, 4'd8},  // R8
    '{1'b1, 10'd160,  32'h001C_0000, 10'd160, 32'h001C_0000, 4'd6}   // R6 sel1
  };

  logic        clk;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] clk_stop_a;
  logic [31:0] clk_stop_b;
  logic [2:0]  pclk_div_sel;

  int checks;
  int fails;
  int cycles;
  bit done;

  clkgate_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_stop_a(clk_stop_a),
    .clk_stop_b(clk_stop_b), .pclk_div_sel(pclk_div_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic read_word(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0;
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic write_word(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    checks = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset-state outputs (R9, R10)
    #1;
    check("R9 div after reset", {29'd0, pclk_div_sel}, 32'd4);
    check("R10 stop A out", clk_stop_a, 32'hFFFF_8400);
    check("R10 stop B out", clk_stop_b, 32'h0000_5F30);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) write_word(VECS[i].addr, VECS[i].wdata);
      read_word(VECS[i].chk, rd);
      checks++;
      if (rd !== VECS[i].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual 0x%08h expected 0x%08h",
                 VECS[i].req, i, rd, VECS[i].exp);
      end
    end

    // R9: divider field follows the new clock select
    #1 check("R9 div after write", {29'd0, pclk_div_sel}, 32'd7);
    // R10: exported vectors match the words
    check("R10 stop A", clk_stop_a, 32'h0000_84F2);
    check("R10 stop B", clk_stop_b, 32'h0000_5031);

    // R11: write data with enable low changes nothing
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 10'd7; bus_wdata = 32'h0BAD_F00D;
    repeat (2) @(negedge clk);
    read_word(10'd7, rd);
    check("R11 we low", rd, 32'hDEAD_BEEF);
    @(negedge clk);
    bus_addr = 10'd145; bus_wdata = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    #1 check("R11 clear alias idle", clk_stop_a, 32'h0000_84F2);

    // R8: out-of-range write does not wrap onto word 0 or move outputs
    write_word(10'd904, 32'h5555_AAAA);
    read_word(10'd0, rd);
    check("R8 word 0 kept", rd, 32'h0600_0003);
    check("R8 stop A kept", clk_stop_a, 32'h0000_84F2);

    // Second reset restores everything (R1, R2, R9)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_word(10'd7, rd);
    check("R2 word 7 after reset", rd, 32'h0);
    read_word(10'd903, rd);
    check("R2 word 903 after reset", rd, 32'h0);
    read_word(10'd160, rd);
    check("R1 sel1 after reset", rd, 32'h8690_0000);
    check("R9 div after reset", {29'd0, pclk_div_sel}, 32'd4);
    check("R1 stop A after reset", clk_stop_a, 32'hFFFF_8400);
    check("R1 stop B after reset", clk_stop_b, 32'h0000_5F30);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule